// File: doc/BRIEF.md
# I/O Wait-State and Composite Select Unit

This unit drives the external-bus strobes for four address spaces: program, data, boot and an 11-bit I/O space. The core presents a request with a space code, an address and a read/write flag, and holds it until the unit returns a one-cycle ready pulse. While an access runs, exactly one active-low space select is held low, together with an active-low read or write strobe. The external address is registered with the select.

For I/O accesses the unit splits the 2048-location space into four 512-location regions. Each region has its own 3-bit wait-state register, so an I/O access holds its strobes for one to eight cycles. Memory-space accesses take a single strobe cycle. A composite select output combines any subset of the four individual selects, as chosen by a 4-bit mask, and has the same registered timing as those selects. A bus-yield input blanks every select while the external bus is handed to another master. While it is high, it also freezes the running wait count. A small write port loads the wait and mask registers.

Top module: `xbs_strobe_ctl`

## Requirements
- R1: After synchronous reset, every select, the composite select and both strobes are high, ready is low and the external address is 0. All four wait registers reset to 7 and the mask resets to 4'b1111.
- R2: The I/O region, and with it the wait register used, is taken from address bits [10:9]: 0 picks wait register 0, 1 picks register 1, 2 picks register 2 and 3 picks register 3.
- R3: An I/O access (space code 3) holds the I/O select and its strobe low for exactly 1+N cycles, where N (0 to 7) is the selected region's wait value.
- R4: A program (code 0), data (code 1) or boot (code 2) access holds its select and strobe low for exactly one cycle.
- R5: During an access, only the select of the requested space is low. rd_n is low for a read (req_write=0) and wr_n is low for a write.
- R6: For an I/O access, ext_addr carries the low 11 request address bits and drives the upper 3 bits as 0. For the other spaces, ext_addr carries all 14 bits.
- R7: req_ready pulses high for one cycle, in the cycle right after the strobes are released. In that cycle every select is high.
- R8: comp_sel_n is low in exactly the cycles in which a select whose mask bit is set is low. Mask bit 0 enables program, bit 1 data, bit 2 boot and bit 3 I/O.
- R9: A request present during the ready cycle is not accepted. The earliest next access starts its strobes two cycles after the ready cycle's edge, so every select is high for at least two cycles between accesses.
- R10: While bus_yield is high, no request is accepted. At each edge where bus_yield is high, all selects (the composite included) go high for the following cycle, and the wait count does not advance.
- R11: A write with cfg_addr 0 to 3 loads the wait register of that index from cfg_wdata[2:0]. cfg_addr 4 loads the mask from cfg_wdata[3:0]. Writes to cfg_addr 5 to 7 have no effect.
- R12: The wait value is captured when the access is accepted. Rewriting that region's register during the access does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core access request, held until ready |
| req_space | input | 2 | 0 program, 1 data, 2 boot, 3 I/O |
| req_addr | input | 14 | Request address |
| req_write | input | 1 | 1 write, 0 read |
| req_ready | output | 1 | One-cycle completion pulse |
| bus_yield | input | 1 | External bus granted away; blanks selects |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index (0-3 wait, 4 mask) |
| cfg_wdata | input | 4 | Register write data |
| ext_addr | output | 14 | External address |
| prog_sel_n | output | 1 | Program-space select, active low |
| data_sel_n | output | 1 | Data-space select, active low |
| boot_sel_n | output | 1 | Boot-space select, active low |
| io_sel_n | output | 1 | I/O-space select, active low |
| comp_sel_n | output | 1 | Composite select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest state to reach is a running I/O access that is interrupted. In one case bus_yield rises partway through the wait count. In the other, the region's wait register is rewritten while the count is running. Both require stimulus placed on a chosen cycle inside an access, not at its edges. The bench steps cycle by cycle through such accesses. In the first case it raises yield for exactly one cycle after the first strobe cycle and checks that the blanked cycle is not counted. In the second it writes the register during the second strobe cycle and checks that the length still follows the old value. A separate case presents a new request in the very cycle ready is seen, so the accept guard is exercised.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_BOOT = 2'd2,
    SP_IO   = 2'd3
  } space_e;
endpackage

// File: rtl/xbs_cfg_regs.sv
module xbs_cfg_regs #(
  parameter int NREG = 4,
  parameter int WS_W = 3,
  parameter int NSEL = 4,
  parameter int CA_W = 3,
  parameter int DW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CA_W-1:0]      cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [NREG*WS_W-1:0] wait_flat,
  output logic [NSEL-1:0]      sel_mask
);
  for (genvar g = 0; g < NREG; g++) begin : g_wait
    logic [WS_W-1:0] wreg_q;
    always_ff @(posedge clk) begin
      if (rst)
        wreg_q <= '1;
      else if (cfg_we && cfg_addr == CA_W'(g))
        wreg_q <= cfg_wdata[WS_W-1:0];
    end
    assign wait_flat[g*WS_W +: WS_W] = wreg_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sel_mask <= '1;
    else if (cfg_we && cfg_addr == CA_W'(NREG))
      sel_mask <= cfg_wdata[NSEL-1:0];
  end

  // a write to an index above the mask leaves the mask untouched
  p_hi_index_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr > CA_W'(NREG)) |=> $stable(sel_mask));
endmodule

// File: rtl/xbs_access_fsm.sv
module xbs_access_fsm #(
  parameter int NREG   = 4,
  parameter int WS_W   = 3,
  parameter int RSEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 is_io,
  input  logic [RSEL_W-1:0]    region,
  input  logic [NREG*WS_W-1:0] wait_flat,
  input  logic                 bus_yield,
  output logic                 accept,
  output logic                 active_nx,
  output logic                 ready_q
);
  logic            busy_q, busy_d, done;
  logic [WS_W-1:0] cnt_q, cnt_d, wait_sel;

  assign wait_sel = wait_flat[region*WS_W +: WS_W];
  assign accept   = req_valid && !busy_q && !ready_q && !bus_yield;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = is_io ? wait_sel : '0;
    end else if (busy_q && !bus_yield) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign active_nx = busy_d && !bus_yield;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      ready_q <= done;
    end
  end

  p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> !ready_q);
  p_yield_freezes_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && bus_yield) |=> (busy_q && cnt_q == $past(cnt_q)));
  p_no_take_on_ready_r9: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> !busy_q);
endmodule

// File: rtl/xbs_strobe_gen.sv
module xbs_strobe_gen #(
  parameter int EXT_AW = 14,
  parameter int IO_AW  = 11,
  parameter int NSEL   = 4,
  parameter int SP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [SP_W-1:0]   space,
  input  logic              write,
  input  logic [EXT_AW-1:0] addr,
  input  logic              active_nx,
  input  logic [NSEL-1:0]   sel_mask,
  input  logic              bus_yield,
  output logic [NSEL-1:0]   sel_n_q,
  output logic              comp_n_q,
  output logic              rd_n_q,
  output logic              wr_n_q,
  output logic [EXT_AW-1:0] ext_addr_q
);
  localparam int HI_W = EXT_AW - IO_AW;

  logic [SP_W-1:0] space_q, sp_nx;
  logic            wr_q, wr_nx, io_req;
  logic [NSEL-1:0] sel_on;

  assign sp_nx  = accept ? space : space_q;
  assign wr_nx  = accept ? write : wr_q;
  assign io_req = (xbs_pkg::space_e'(space) == xbs_pkg::SP_IO);

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_on[g] = active_nx && (sp_nx == SP_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      space_q    <= '0;
      wr_q       <= 1'b0;
      sel_n_q    <= '1;
      comp_n_q   <= 1'b1;
      rd_n_q     <= 1'b1;
      wr_n_q     <= 1'b1;
      ext_addr_q <= '0;
    end else begin
      space_q  <= sp_nx;
      wr_q     <= wr_nx;
      sel_n_q  <= ~sel_on;
      comp_n_q <= ~|(sel_on & sel_mask);
      rd_n_q   <= !(active_nx && !wr_nx);
      wr_n_q   <= !(active_nx && wr_nx);
      if (accept)
        ext_addr_q <= io_req ? {{HI_W{1'b0}}, addr[IO_AW-1:0]} : addr;
    end
  end

  p_one_select_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n_q) <= 1);
  p_strobe_with_select_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_n_q && wr_n_q) == (&sel_n_q));
  p_comp_follows_mask_r8: assert property (@(posedge clk) disable iff (rst)
    comp_n_q == !(|(~sel_n_q & $past(sel_mask))));
  p_yield_blanks_r10: assert property (@(posedge clk) disable iff (rst)
    bus_yield |=> (&sel_n_q && comp_n_q));
  p_io_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_n_q[NSEL-1] |-> (ext_addr_q[EXT_AW-1:IO_AW] == '0));
endmodule

// File: rtl/xbs_strobe_ctl.sv
module xbs_strobe_ctl #(
  parameter int EXT_AW = 14,
  parameter int IO_AW  = 11,
  parameter int NREG   = 4,
  parameter int WS_W   = 3,
  parameter int NSEL   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_space,
  input  logic [EXT_AW-1:0] req_addr,
  input  logic              req_write,
  output logic              req_ready,
  input  logic              bus_yield,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [3:0]        cfg_wdata,
  output logic [EXT_AW-1:0] ext_addr,
  output logic              prog_sel_n,
  output logic              data_sel_n,
  output logic              boot_sel_n,
  output logic              io_sel_n,
  output logic              comp_sel_n,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int RSEL_W = $clog2(NREG);
  localparam int CA_W   = 3;
  localparam int DW     = 4;
  localparam int SP_W   = 2;

  xbs_pkg::space_e       req_sp;
  logic [NREG*WS_W-1:0]  wait_flat;
  logic [NSEL-1:0]       sel_mask, sel_n;
  logic                  accept, active_nx, ready_q;

  assign req_sp = xbs_pkg::space_e'(req_space);

  xbs_cfg_regs #(.NREG(NREG), .WS_W(WS_W), .NSEL(NSEL), .CA_W(CA_W), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wait_flat(wait_flat), .sel_mask(sel_mask)
  );

  xbs_access_fsm #(.NREG(NREG), .WS_W(WS_W), .RSEL_W(RSEL_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .is_io(req_sp == xbs_pkg::SP_IO),
    .region(req_addr[IO_AW-1 -: RSEL_W]), .wait_flat(wait_flat),
    .bus_yield(bus_yield), .accept(accept), .active_nx(active_nx),
    .ready_q(ready_q)
  );

  xbs_strobe_gen #(.EXT_AW(EXT_AW), .IO_AW(IO_AW), .NSEL(NSEL), .SP_W(SP_W)) u_stb (
    .clk(clk), .rst(rst), .accept(accept), .space(req_space),
    .write(req_write), .addr(req_addr), .active_nx(active_nx),
    .sel_mask(sel_mask), .bus_yield(bus_yield), .sel_n_q(sel_n),
    .comp_n_q(comp_sel_n), .rd_n_q(rd_n), .wr_n_q(wr_n),
    .ext_addr_q(ext_addr)
  );

  assign req_ready  = ready_q;
  assign prog_sel_n = sel_n[0];
  assign data_sel_n = sel_n[1];
  assign boot_sel_n = sel_n[2];
  assign io_sel_n   = sel_n[3];

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (&sel_n && comp_sel_n && rd_n && wr_n));
  p_gap_after_ready_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> (&sel_n && comp_sel_n));
endmodule

// File: tb/xbs_strobe_ctl_tb.sv
`timescale 1ns/1ps
module xbs_strobe_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, bus_yield = 1'b0;
  logic [1:0]  req_space = '0;
  logic [13:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic        req_ready, prog_sel_n, data_sel_n, boot_sel_n, io_sel_n;
  logic        comp_sel_n, rd_n, wr_n;
  logic [13:0] ext_addr;

  int  nchk = 0, nfail = 0, gap_cnt = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  xbs_strobe_ctl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_space(req_space),
    .req_addr(req_addr), .req_write(req_write), .req_ready(req_ready),
    .bus_yield(bus_yield), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_addr(ext_addr), .prog_sel_n(prog_sel_n),
    .data_sel_n(data_sel_n), .boot_sel_n(boot_sel_n), .io_sel_n(io_sel_n),
    .comp_sel_n(comp_sel_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // {space[1:0], addr[13:0], write, len[3:0], comp_low}
  localparam logic [21:0] VEC [0:11] = '{
    {2'd3, 14'h0000, 1'b0, 4'd1, 1'b1},
    {2'd3, 14'h01FF, 1'b1, 4'd1, 1'b1},
    {2'd3, 14'h0200, 1'b0, 4'd4, 1'b1},
    {2'd3, 14'h03FF, 1'b1, 4'd4, 1'b1},
    {2'd3, 14'h0400, 1'b0, 4'd6, 1'b1},
    {2'd3, 14'h05FF, 1'b0, 4'd6, 1'b1},
    {2'd3, 14'h0600, 1'b1, 4'd8, 1'b1},
    {2'd3, 14'h07FF, 1'b0, 4'd8, 1'b1},
    {2'd3, 14'h3A00, 1'b1, 4'd4, 1'b1},
    {2'd0, 14'h1234, 1'b0, 4'd1, 1'b1},
    {2'd1, 14'h3FDF, 1'b1, 4'd1, 1'b1},
    {2'd2, 14'h0005, 1'b0, 4'd1, 1'b1}
  };

  function automatic logic [3:0] pins();
    return {io_sel_n, boot_sel_n, data_sel_n, prog_sel_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [1:0] sp, input logic [13:0] a,
                        input logic w, input int exp_len, input logic exp_comp_low,
                        input bit no_wait, input string tag);
    int lowcnt = 0;
    bit first = 1, fin = 0;
    logic [13:0] exp_addr;
    exp_addr = (sp == 2'd3) ? (a & 14'h07FF) : a;
    gap_cnt = 0;
    if (!no_wait) @(negedge clk);
    req_space = sp; req_addr = a; req_write = w; req_valid = 1'b1;
    for (int k = 0; k < 64 && !fin; k++) begin
      @(negedge clk);
      if (req_ready) begin
        chk(pins() == 4'hF && comp_sel_n && rd_n && wr_n, "R7", "idle in ready cycle",
            {pins(), comp_sel_n, rd_n, wr_n}, 7'h7F);
        req_valid = 1'b0;
        fin = 1;
      end else if (pins() != 4'hF) begin
        lowcnt++;
        chk(pins() == ~(4'b0001 << sp), "R5", "select pattern", pins(), ~(4'b0001 << sp));
        chk({rd_n, wr_n} == (w ? 2'b10 : 2'b01), "R5", "strobe", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
        chk(comp_sel_n == !exp_comp_low, "R8", "composite", comp_sel_n, !exp_comp_low);
        if (first) chk(ext_addr == exp_addr, "R6", "ext_addr", ext_addr, exp_addr);
        first = 0;
      end else if (first) begin
        gap_cnt++;
      end
    end
    if (!fin) begin
      chk(0, tag, "no ready within 64 cycles", 0, 1);
      req_valid = 1'b0;
    end
    chk(lowcnt == exp_len, tag, "strobe length", lowcnt, exp_len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pins() == 4'hF && comp_sel_n && rd_n && wr_n, "R1", "outputs high",
        {pins(), comp_sel_n, rd_n, wr_n}, 7'h7F);
    chk(!req_ready && ext_addr == '0, "R1", "ready and addr", {req_ready, ext_addr}, 0);
    // R1: waits reset to 7, mask to all ones
    access(2'd3, 14'h0650, 1'b0, 8, 1'b1, 0, "R1");
    access(2'd1, 14'h0100, 1'b0, 1, 1'b1, 0, "R1");

    // R11 program waits 0,3,5,7
    cfg_write(3'd0, 4'd0);
    cfg_write(3'd1, 4'd3);
    cfg_write(3'd2, 4'd5);
    cfg_write(3'd3, 4'd7);

    // R2 R3 R4 R6 vector walk
    foreach (VEC[i]) begin
      access(VEC[i][21:20], VEC[i][19:6], VEC[i][5], int'(VEC[i][4:1]), VEC[i][0], 0,
             (VEC[i][21:20] == 2'd3) ? "R2/R3" : "R4");
    end

    // R11 writes to indices 5..7 ignored
    cfg_write(3'd5, 4'd0);
    cfg_write(3'd6, 4'd0);
    cfg_write(3'd7, 4'd0);
    access(2'd3, 14'h0200, 1'b0, 4, 1'b1, 0, "R11");
    access(2'd3, 14'h0600, 1'b0, 8, 1'b1, 0, "R11");
    access(2'd2, 14'h0010, 1'b0, 1, 1'b1, 0, "R11");

    // R8 mask subsets
    cfg_write(3'd4, 4'b0011);
    access(2'd2, 14'h0020, 1'b0, 1, 1'b0, 0, "R8");
    access(2'd0, 14'h0021, 1'b1, 1, 1'b1, 0, "R8");
    access(2'd1, 14'h0022, 1'b0, 1, 1'b1, 0, "R8");
    access(2'd3, 14'h0023, 1'b0, 1, 1'b0, 0, "R8");
    cfg_write(3'd4, 4'b1000);
    access(2'd3, 14'h0024, 1'b1, 1, 1'b1, 0, "R8");
    access(2'd0, 14'h0025, 1'b0, 1, 1'b0, 0, "R8");
    cfg_write(3'd4, 4'b1111);

    // R9 request presented in the ready cycle
    access(2'd0, 14'h0100, 1'b0, 1, 1'b1, 0, "R9");
    access(2'd1, 14'h0200, 1'b0, 1, 1'b1, 1, "R9");
    chk(gap_cnt == 1, "R9", "high samples before next access", gap_cnt, 1);

    // R12 rewrite of the active region's wait register mid-access
    @(negedge clk);
    req_space = 2'd3; req_addr = 14'h0400; req_write = 1'b0; req_valid = 1'b1;
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (req_ready) begin req_valid = 1'b0; break; end
      if (!io_sel_n) begin
        lows++;
        if (lows == 2) begin cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 4'd0; end
      end
    end
    chk(lows == 6, "R12", "length kept after rewrite", lows, 6);
    access(2'd3, 14'h0400, 1'b0, 1, 1'b1, 0, "R12");

    // R10 bus yield: no accept, blanking, frozen count
    cfg_write(3'd1, 4'd1);
    @(negedge clk);
    bus_yield = 1'b1;
    req_space = 2'd3; req_addr = 14'h0300; req_write = 1'b1; req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(pins() == 4'hF && comp_sel_n && !req_ready, "R10", "no accept under yield",
          {pins(), comp_sel_n, req_ready}, 5'h1E);
    end
    bus_yield = 1'b0;
    @(negedge clk);
    chk(!io_sel_n && !wr_n, "R10", "accept after yield", {io_sel_n, wr_n}, 0);
    bus_yield = 1'b1;
    @(negedge clk);
    chk(pins() == 4'hF && comp_sel_n && wr_n, "R10", "blanked mid access",
        {pins(), comp_sel_n, wr_n}, 6'h3F);
    bus_yield = 1'b0;
    @(negedge clk);
    chk(!io_sel_n && !comp_sel_n, "R10", "resumes after yield", {io_sel_n, comp_sel_n}, 0);
    @(negedge clk);
    chk(req_ready && io_sel_n, "R10", "count frozen, ends after 2 strobes",
        {req_ready, io_sel_n}, 2'b11);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R7", "ready lasts one cycle", req_ready, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule